// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit keeps the eight-bit status byte of a small serial non-volatile memory and rules, cycle by cycle, whether a status update or an array byte write may go ahead. It stores the write-enable latch, a two-bit block-protect level and a lock-enable bit. It combines them with an active-low lock pin, the internal busy flag and a candidate array address to produce two grant flags and the byte a status read returns.

The command decoder in front of it sends one-cycle strobes when a command completes: set-enable, clear-enable, status write (carrying the data byte) and array write. An accepted status write is only staged. The new protect level and lock-enable reach the stored state when the internal write cycle ends, which is when the busy input falls. While busy is high, every status bit reads as one, both grants are withheld and all command strobes are dropped.

Top module: `wp_status_unit`

## Requirements
- R1: After reset, `stat_o` is 0x00 and both grant outputs are 0.
- R2: While `busy_i` is 0, `stat_o` is bit 7 = lock-enable, bits 6..4 = 0, bits 3..2 = protect level (bit 3 is the upper level bit), bit 1 = write-enable latch, and bit 0 = 0.
- R3: While `busy_i` is 1, `stat_o` is 0xFF and both `stat_wr_ok_o` and `arr_wr_ok_o` are 0.
- R4: A `cmd_wren_i` strobe with `busy_i` low sets the write-enable latch from the next cycle.
- R5: A strobe on `cmd_wrdi_i`, `cmd_wrsr_i` or `cmd_write_i` with `busy_i` low clears the write-enable latch from the next cycle. If it comes in the same cycle as `cmd_wren_i`, the clear wins.
- R6: `stat_wr_ok_o` is 1 only when the latch is 1, `busy_i` is 0, and the lock is not active. The lock is active when `lock_pin_ni` is 0 and lock-enable is 1.
- R7: A `cmd_wrsr_i` strobe that arrives while `stat_wr_ok_o` is 0 leaves the lock-enable and protect level unchanged.
- R8: An accepted status write stages bit 7 and bits 3..2 of `stat_wdata_i`. These become visible the cycle after `busy_i` falls and not before. The other data bits are discarded.
- R9: With the default 10-bit address, the protect levels are: 0 protects nothing, 1 protects 0x300..0x3FF, 2 protects 0x200..0x3FF, and 3 protects the whole array.
- R10: `arr_wr_ok_o` is 1 exactly when the latch is 1, `busy_i` is 0 and `arr_addr_i` is outside the protected range. The lock pin has no effect on it.
- R11: While `busy_i` is 1, all command strobes are ignored and the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| busy_i | input | 1 | internal write cycle in progress |
| lock_pin_ni | input | 1 | hardware lock pin, active low |
| cmd_wren_i | input | 1 | set-enable command strobe |
| cmd_wrdi_i | input | 1 | clear-enable command strobe |
| cmd_wrsr_i | input | 1 | status write completed strobe |
| cmd_write_i | input | 1 | array write completed strobe |
| stat_wdata_i | input | 8 | data byte of the status write |
| arr_addr_i | input | ADDR_W | candidate array address |
| stat_o | output | 8 | status byte for reads |
| stat_wr_ok_o | output | 1 | status update permitted |
| arr_wr_ok_o | output | 1 | array write to `arr_addr_i` permitted |

## Verification
The assertions assume that command strobes last one cycle. They also assume that a staged status write is always followed by a busy pulse, since the commit is tied to the falling edge of busy. The stimulus raises busy for at least one full cycle after each accepted status write. It changes the lock pin and the address only between clock edges, with no strobe pending. The strobe-priority checks assume mutually exclusive strobes, except in the one deliberate case where set and clear are sent together.

// File: rtl/wp_prot_pkg.sv
package wp_prot_pkg;
  localparam int STAT_W = 8;

  localparam int POS_LOCK_EN = 7;
  localparam int POS_LVL_HI  = 3;
  localparam int POS_LVL_LO  = 2;
  localparam int POS_WEN     = 1;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_QTR  = 2'd1,
    LVL_HALF = 2'd2,
    LVL_ALL  = 2'd3
  } prot_lvl_e;

  typedef struct packed {
    logic      lock_en;
    prot_lvl_e lvl;
  } prot_cfg_t;

  localparam prot_cfg_t CFG_RESET = '{lock_en: 1'b0, lvl: LVL_NONE};
endpackage

// File: rtl/wp_wen_ctrl.sv
module wp_wen_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wen_o
);
  logic wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wen_q <= 1'b0;
    else if (clr_i) wen_q <= 1'b0;   // clear has priority
    else if (set_i) wen_q <= 1'b1;
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/wp_cfg_store.sv
module wp_cfg_store
  import wp_prot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      busy_i,
  input  logic      stage_i,
  input  prot_cfg_t stage_cfg_i,
  output prot_cfg_t cfg_o,
  output logic      commit_o
);
  logic      busy_q;
  logic      pend_v_q;
  prot_cfg_t pend_q;
  prot_cfg_t cfg_q;
  logic      commit;

  assign commit = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= CFG_RESET;
      cfg_q    <= CFG_RESET;
    end else begin
      busy_q <= busy_i;
      if (commit && pend_v_q) cfg_q <= pend_q;
      if (stage_i) begin
        pend_q   <= stage_cfg_i;
        pend_v_q <= 1'b1;
      end else if (commit) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign commit_o = commit;
endmodule

// File: rtl/wp_blk_decode.sv
module wp_blk_decode
  import wp_prot_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  prot_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP_LSB = ADDR_W - 2;

  logic [1:0] quarter;

  generate
    if (ADDR_W >= 2) begin : g_split
      assign quarter = addr_i[ADDR_W-1:TOP_LSB];
    end else begin : g_tiny
      assign quarter = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      LVL_NONE: hit_o = 1'b0;
      LVL_QTR:  hit_o = (quarter == 2'b11);
      LVL_HALF: hit_o = quarter[1];
      LVL_ALL:  hit_o = 1'b1;
      default:  hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wp_prot_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              lock_pin_ni,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic              cmd_write_i,
  input  logic [7:0]        stat_wdata_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic [7:0]        stat_o,
  output logic              stat_wr_ok_o,
  output logic              arr_wr_ok_o
);
  logic      wen_w;
  logic      set_w;
  logic      clr_w;
  logic      stage_w;
  logic      hw_lock_w;
  logic      blk_hit_w;
  logic      commit_w;
  prot_cfg_t cfg_w;
  prot_cfg_t stage_cfg_w;
  logic [STAT_W-1:0] stat_img;
  logic      unused_wdata;

  assign set_w = cmd_wren_i & ~busy_i;
  assign clr_w = (cmd_wrdi_i | cmd_wrsr_i | cmd_write_i) & ~busy_i;

  assign hw_lock_w    = ~lock_pin_ni & cfg_w.lock_en;
  assign stat_wr_ok_o = wen_w & ~hw_lock_w & ~busy_i;
  assign arr_wr_ok_o  = wen_w & ~blk_hit_w & ~busy_i;

  assign stage_w     = cmd_wrsr_i & stat_wr_ok_o;
  assign stage_cfg_w = '{lock_en: stat_wdata_i[POS_LOCK_EN],
                         lvl:     prot_lvl_e'(stat_wdata_i[POS_LVL_HI:POS_LVL_LO])};
  assign unused_wdata = ^{stat_wdata_i[6:4], stat_wdata_i[1:0]};

  always_comb begin
    stat_img                        = '0;
    stat_img[POS_LOCK_EN]           = cfg_w.lock_en;
    stat_img[POS_LVL_HI:POS_LVL_LO] = cfg_w.lvl;
    stat_img[POS_WEN]               = wen_w;
  end

  assign stat_o = busy_i ? {STAT_W{1'b1}} : stat_img;

  wp_wen_ctrl u_wen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (clr_w),
    .wen_o  (wen_w)
  );

  wp_cfg_store u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .stage_i     (stage_w),
    .stage_cfg_i (stage_cfg_w),
    .cfg_o       (cfg_w),
    .commit_o    (commit_w)
  );

  wp_blk_decode #(.ADDR_W(ADDR_W)) u_blk (
    .lvl_i  (cfg_w.lvl),
    .addr_i (arr_addr_i),
    .hit_o  (blk_hit_w)
  );
endmodule

// File: rtl/wp_status_chk.sv
module wp_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       lock_pin_ni,
  input logic       cmd_wren_i,
  input logic       cmd_wrdi_i,
  input logic       cmd_wrsr_i,
  input logic       cmd_write_i,
  input logic [7:0] stat_o,
  input logic       stat_wr_ok_o,
  input logic       arr_wr_ok_o,
  input logic       wen_w,
  input logic       commit_w,
  input logic [2:0] cfg_w
);
  a_r3_busy_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> stat_o == 8'hFF);

  a_r3_busy_blocks_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!stat_wr_ok_o && !arr_wr_ok_o));

  a_r6_lock_blocks_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !lock_pin_ni && cfg_w[2]) |-> !stat_wr_ok_o);

  a_r4_wren_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wren_i && !busy_i && !cmd_wrdi_i && !cmd_wrsr_i && !cmd_write_i) |=> wen_w);

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_wrdi_i || cmd_wrsr_i || cmd_write_i) && !busy_i) |=> !wen_w);

  a_r11_busy_holds_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(wen_w));

  a_r8_cfg_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> $stable(cfg_w));

  a_r9_full_block_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_w[1:0] == 2'b11) |-> !arr_wr_ok_o);
endmodule

bind wp_status_unit wp_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .lock_pin_ni  (lock_pin_ni),
  .cmd_wren_i   (cmd_wren_i),
  .cmd_wrdi_i   (cmd_wrdi_i),
  .cmd_wrsr_i   (cmd_wrsr_i),
  .cmd_write_i  (cmd_write_i),
  .stat_o       (stat_o),
  .stat_wr_ok_o (stat_wr_ok_o),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .wen_w        (wen_w),
  .commit_w     (commit_w),
  .cfg_w        (cfg_w)
);

// File: tb/sim_wp_status_unit.sv
module sim_wp_status_unit;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic          lock_n = 1'b1;
  logic          wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, wr = 1'b0;
  logic [7:0]    wdata = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    stat;
  logic          s_ok, a_ok;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wp_status_unit #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .lock_pin_ni(lock_n),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr), .cmd_write_i(wr),
    .stat_wdata_i(wdata), .arr_addr_i(addr),
    .stat_o(stat), .stat_wr_ok_o(s_ok), .arr_wr_ok_o(a_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int img(input int le, input int lvl, input int we);
    return (le << 7) | (lvl << 2) | (we << 1);
  endfunction

  function automatic int prot(input int lvl, input int a);
    case (lvl)
      0: return 0;
      1: return (a >= 768) ? 1 : 0;
      2: return (a >= 512) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  task automatic pulse(input logic s, input logic c, input logic w, input logic a,
                       input logic [7:0] d);
    @(negedge clk);
    wren = s; wrdi = c; wrsr = w; wr = a; wdata = d;
    @(negedge clk);
    wren = 0; wrdi = 0; wrsr = 0; wr = 0;
    #1;
  endtask

  task automatic busy_cycle(input int n);
    @(negedge clk);
    busy = 1;
    #1;
    chk("R3 stat", stat, 8'hFF);
    chk("R3 grants", {s_ok, a_ok}, 0);
    repeat (n) @(negedge clk);
    busy = 0;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m_le, m_lvl;
    m_le = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 stat", stat, 0);
    chk("R1 grants", {s_ok, a_ok}, 0);
    rst_n = 1;

    pulse(1, 0, 0, 0, 0);
    chk("R4 set", stat, img(0, 0, 1));

    // sweep every protect level and lock-enable value
    for (int cfg = 0; cfg < 8; cfg++) begin
      int le, lvl;
      le = cfg >> 2; lvl = cfg & 3;
      lock_n = 1;
      pulse(1, 0, 0, 0, 0);
      pulse(0, 0, 1, 0, 8'((le << 7) | 8'h73 | (lvl << 2)));
      chk("R8 not yet", stat, img(m_le, m_lvl, 0));
      chk("R5 wrsr clears", stat[1], 0);
      busy_cycle(2);
      m_le = le; m_lvl = lvl;
      chk("R8 applied", stat, img(le, lvl, 0));
      chk("R2 unused zero", stat[6:4], 0);
      for (int a = 0; a < 1024; a++) begin
        addr = AW'(a);
        #1;
        chk("R10 wen off", a_ok, 0);
      end
      pulse(1, 0, 0, 0, 0);
      for (int lp = 0; lp < 2; lp++) begin
        lock_n = lp[0];
        for (int a = 0; a < 1024; a++) begin
          addr = AW'(a);
          #1;
          chk("R9 range", a_ok, 1 - prot(lvl, a));
        end
        chk("R6 lock", s_ok, (lp == 0 && le == 1) ? 0 : 1);
      end
      lock_n = 1;
      pulse(0, 1, 0, 0, 0);
      chk("R5 wrdi", stat, img(le, lvl, 0));
    end

    // R7: locked status write ignored
    lock_n = 0;
    pulse(1, 0, 0, 0, 0);
    chk("R6 locked", s_ok, 0);
    pulse(0, 0, 1, 0, 8'h84);
    busy_cycle(1);
    chk("R7 locked keeps", stat, img(1, 3, 0));
    lock_n = 1;
    pulse(0, 0, 1, 0, 8'h00);
    busy_cycle(1);
    chk("R7 wen off keeps", stat, img(1, 3, 0));

    // R5: clear beats set, array write clears
    pulse(1, 1, 0, 0, 0);
    chk("R5 clear wins", stat[1], 0);
    pulse(1, 0, 0, 0, 0);
    chk("R4 set again", stat[1], 1);
    pulse(0, 0, 0, 1, 0);
    chk("R5 write clears", stat[1], 0);

    // R11: strobes ignored while busy
    @(negedge clk); busy = 1;
    pulse(1, 0, 0, 0, 0);
    @(negedge clk); busy = 0; #1;
    chk("R11 wren dropped", stat[1], 0);
    pulse(1, 0, 0, 0, 0);
    @(negedge clk); busy = 1;
    pulse(0, 1, 0, 0, 0);
    @(negedge clk); busy = 0; #1;
    chk("R11 wrdi dropped", stat[1], 1);
    chk("R2 final", stat, img(1, 3, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule